// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Incrementing Pointer

This block is a two-wire serial bus slave that gives a host controller byte-wide access to a bank of 26 control registers. The serial clock and data lines are oversampled on a fast system clock, which is faster than the serial clock. Start and stop conditions are found from the sampled lines. The first byte of each transfer carries a 7-bit device address and a direction bit. The slave acknowledges only its own address, and one bit of that address comes from a strap input.

In a write, the first byte after the address loads a register pointer. Each further byte goes to the register that the pointer selects, and the pointer then steps forward. A read returns bytes from consecutive registers, starting at the current pointer. The pointer wraps from the last register back to the first.

All registers come out of reset with fixed defaults. Four consecutive registers hold the bytes of a 32-bit frequency word, least significant byte first. The word given to downstream logic is updated only when its top byte is written. Because of this, a partly rewritten word never reaches the output.

Top module: `i2c_reg_slave`

## Requirements
- R1: A start condition (SDA falls while SCL is high) begins a transfer. A stop condition (SDA rises while SCL is high) ends any transfer at once, even in the middle of a byte, and releases SDA. A byte cut short by a stop writes no register.
- R2: The first byte after a start is received MSB first: seven address bits, then a direction bit (0 = write, 1 = read). The slave address is 7'b0101000 with bit 1 replaced by `addr_sel_i`, giving 0x28 or 0x2A. On a match, the slave pulls SDA low during the ninth clock. Otherwise it leaves SDA released and ignores the bus until the next start.
- R3: In a write, the byte after the address loads the register pointer and is acknowledged. A value of 26 or more loads pointer 0.
- R4: In a write, each later byte is acknowledged, stored in the register the pointer selects, and then the pointer increments. Registers that are not addressed keep their values.
- R5: A read returns the register at the pointer, MSB first, and then increments the pointer. The slave sends the next register's byte for as long as the host acknowledges, and stops driving after a host not-acknowledge.
- R6: The pointer wraps from register 25 to register 0, for both reads and writes.
- R7: After reset, every register is 0x00 except these: register 1 is 0x48 (bits 3 and 6 set), register 6 is 0x10 (bit 4 set), and registers 2 to 5 hold 0x16, 0x7C, 0xF0, 0x21.
- R8: `freq_word_o` resets to 0x21F07C16. It changes only in the cycle after register 5 is written, and then takes the value {new byte, reg4, reg3, reg2}. Writes to registers 2 to 4 alone leave it unchanged.
- R9: A repeated start at any point, including inside the address byte, clears the bit counter and restarts address reception.
- R10: `regs_o` bits [8i+7:8i] show register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Drive SDA low when 1 (open-drain enable) |
| addr_sel_i | input | 1 | Strap for slave address bit 1 |
| regs_o | output | 208 | Flattened register bank, register i at [8i+7:8i] |
| freq_word_o | output | 32 | Committed 32-bit frequency word |

## Verification
The byte that completes the frequency word is written to register 5, and the same edge commits the word. Because of this, the committed word must contain the incoming byte and not the register's old contents. The bench provokes this case in two ways. First, it writes registers 2 to 4 alone and checks that the word has not moved. Then it writes register 5, both on its own and as the last byte of a four-byte burst, and compares the word with the bench's model. A second shared edge comes from the pointer wrap that follows a write to register 25. The bench judges it from a burst that crosses the end of the bank and from a read that starts at register 25.

// File: rtl/i2c_regs_pkg.sv
package i2c_regs_pkg;
  localparam int REG_COUNT = 26;
  localparam int MODE_A_IDX = 1;
  localparam int FREQ_IDX = 2;
  localparam int MODE_B_IDX = 6;
  localparam logic [31:0] FREQ_RESET = 32'h21F0_7C16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_SUB, ST_WDATA, ST_ACK_WAIT, ST_ACK_HOLD,
    ST_RDATA, ST_RACK, ST_RSTART
  } slv_state_e;

  function automatic logic [7:0] reg_reset(input int idx);
    if (idx == MODE_A_IDX) return 8'h48;
    if (idx == MODE_B_IDX) return 8'h10;
    if (idx >= FREQ_IDX && idx < FREQ_IDX + 4) return FREQ_RESET[(idx - FREQ_IDX) * 8 +: 8];
    return 8'h00;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES:0] scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_p[STAGES-1];
  assign scl_prev = scl_p[STAGES];
  assign sda_now  = sda_p[STAGES-1];
  assign sda_prev = sda_p[STAGES];

  assign sda_s_o    = sda_now;
  assign scl_rise_o = scl_now & ~scl_prev;
  assign scl_fall_o = ~scl_now & scl_prev;
  assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_regs_pkg::*;
#(
  parameter int NUM_REGS = REG_COUNT,
  localparam int PTR_W = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [PTR_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [PTR_W-1:0]      rd_idx_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic [31:0]           freq_o
);
  localparam int FREQ_TOP = FREQ_IDX + 3;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= reg_reset(i);
      else if (wr_en_i && wr_idx_i == PTR_W'(i)) q <= wr_data_i;
    end
    assign regs_o[i*8 +: 8] = q;
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx_i == PTR_W'(i)) rd_data_o = regs_o[i*8 +: 8];
  end

  // commit takes the incoming top byte directly, lower bytes from the bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) freq_o <= FREQ_RESET;
    else if (wr_en_i && wr_idx_i == PTR_W'(FREQ_TOP))
      freq_o <= {wr_data_i, regs_o[FREQ_IDX*8 +: 24]};
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_regs_pkg::*;
#(
  parameter int         NUM_REGS    = REG_COUNT,
  parameter logic [6:0] DEV_ADDR    = 7'h28,
  parameter int         SEL_BIT     = 1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic                  addr_sel_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic [31:0]           freq_word_o
);
  localparam int PTR_W = $clog2(NUM_REGS);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  slv_state_e       state, nxt;
  logic [2:0]       cnt;
  logic [6:0]       shreg;
  logic [7:0]       tx, byte_in, rd_data;
  logic [PTR_W-1:0] ptr;
  logic             wr_en;
  logic [6:0]       dev_addr;

  always_comb begin
    dev_addr = DEV_ADDR;
    dev_addr[SEL_BIT] = addr_sel_i;
  end

  assign byte_in = {shreg, sda_s};
  assign wr_en   = (state == ST_WDATA) && scl_rise && (cnt == 3'd7);

  i2c_reg_bank #(.NUM_REGS(NUM_REGS)) i_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(ptr), .wr_data_i(byte_in),
    .rd_idx_i(ptr), .rd_data_o(rd_data),
    .regs_o, .freq_o(freq_word_o)
  );

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NUM_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; nxt <= ST_IDLE; cnt <= '0; shreg <= '0;
      tx <= '0; ptr <= '0; sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE; cnt <= '0; sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state <= ST_ADDR; cnt <= '0; sda_oe_o <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WDATA: if (scl_rise) begin
          shreg <= {shreg[5:0], sda_s};
          cnt   <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            state <= ST_ACK_WAIT;
            if (state == ST_ADDR) begin
              if (byte_in[7:1] != dev_addr) state <= ST_IDLE;
              else if (byte_in[0]) begin
                nxt <= ST_RDATA; tx <= rd_data; ptr <= step(ptr);
              end else nxt <= ST_SUB;
            end else if (state == ST_SUB) begin
              ptr <= (byte_in < 8'(NUM_REGS)) ? byte_in[PTR_W-1:0] : '0;
              nxt <= ST_WDATA;
            end else begin
              ptr <= step(ptr);
              nxt <= ST_WDATA;
            end
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          sda_oe_o <= 1'b1;
          state    <= ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          cnt   <= '0;
          state <= nxt;
          if (nxt == ST_RDATA) begin
            sda_oe_o <= ~tx[7]; tx <= {tx[6:0], 1'b0};
          end else sda_oe_o <= 1'b0;
        end
        ST_RDATA: begin
          if (scl_fall) begin
            sda_oe_o <= ~tx[7]; tx <= {tx[6:0], 1'b0};
          end
          if (scl_rise) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) state <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (scl_fall) sda_oe_o <= 1'b0;
          if (scl_rise) begin
            if (!sda_s) begin
              tx <= rd_data; ptr <= step(ptr); state <= ST_RSTART;
            end else state <= ST_IDLE;
          end
        end
        ST_RSTART: if (scl_fall) begin
          sda_oe_o <= ~tx[7]; tx <= {tx[6:0], 1'b0};
          cnt <= '0; state <= ST_RDATA;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk
  import i2c_regs_pkg::*;
#(
  parameter int NUM_REGS = REG_COUNT,
  localparam int PTR_W = $clog2(NUM_REGS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sda_oe_o,
  input logic [NUM_REGS*8-1:0] regs_o,
  input logic [31:0]           freq_word_o,
  input logic                  wr_en,
  input logic [PTR_W-1:0]      wr_idx,
  input logic [7:0]            wr_data,
  input logic                  stop_det,
  input slv_state_e            state,
  input logic [PTR_W-1:0]      ptr
);
  localparam logic [PTR_W-1:0] FREQ_TOP = PTR_W'(FREQ_IDX + 3);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  // R8
  freq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && wr_idx == FREQ_TOP) |=> $stable(freq_word_o));
  // R8
  freq_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_idx == FREQ_TOP) |=> freq_word_o[31:24] == $past(wr_data));
  // R4
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(regs_o));
  // R6
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_idx == LAST) |=> ptr == '0);
  // R6
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr <= LAST);
  // R1
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (!sda_oe_o && state == ST_IDLE));
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> !sda_oe_o);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.NUM_REGS(NUM_REGS)) i_chk (
  .clk_i, .rst_ni, .sda_oe_o, .regs_o, .freq_word_o,
  .wr_en, .wr_idx(ptr), .wr_data(byte_in), .stop_det, .state, .ptr
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  localparam int N = 26;
  localparam int Q = 8;

  logic clk = 1'b0, rst_ni = 1'b0, scl = 1'b1, sda_m = 1'b1, sel = 1'b0;
  logic sda_oe, sda_line;
  logic [N*8-1:0] regs;
  logic [31:0] freq;

  assign sda_line = sda_m & ~sda_oe;
  always #2 clk = ~clk;

  i2c_reg_slave i_i2c_reg_slave (
    .clk_i(clk), .rst_ni, .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(sel), .regs_o(regs), .freq_word_o(freq)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model[N];
  logic [31:0] mfreq;
  logic [6:0] my_addr = 7'h28;
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; idle(Q); scl = 1'b1; idle(Q); sda_m = 1'b0; idle(Q); scl = 1'b0; idle(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; idle(Q); scl = 1'b1; idle(Q); sda_m = 1'b1; idle(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; idle(Q); scl = 1'b1; idle(2*Q); scl = 1'b0; idle(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; idle(Q); scl = 1'b1; idle(Q); b = sda_line; idle(Q); scl = 1'b0; idle(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ack);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(nack);
  endtask

  task automatic write_regs(input logic [7:0] sub, input int n,
                            input logic [7:0] d0, d1, d2, d3);
    logic ack;
    int p;
    logic [7:0] d;
    bus_start;
    send_byte({my_addr, 1'b0}, ack); chk("R2 address ack", ack, 0);
    send_byte(sub, ack);             chk("R3 subaddress ack", ack, 0);
    p = (sub < N) ? int'(sub) : 0;
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : (i == 2) ? d2 : d3;
      send_byte(d, ack); chk("R4 data ack", ack, 0);
      model[p] = d;
      if (p == 5) mfreq = {d, model[4], model[3], model[2]};
      p = (p + 1) % N;
    end
    bus_stop;
    idle(Q);
  endtask

  task automatic read_regs(input logic [7:0] sub, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    int p;
    bus_start;
    send_byte({my_addr, 1'b0}, ack); chk("R2 address ack", ack, 0);
    send_byte(sub, ack);             chk("R3 subaddress ack", ack, 0);
    p = (sub < N) ? int'(sub) : 0;
    bus_start; // repeated start, R9
    send_byte({my_addr, 1'b1}, ack); chk("R9 read address ack after repeated start", ack, 0);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[p]); tag_q.push_back(tag);
      p = (p + 1) % N;
      recv_byte(i == n - 1, d);
      act_q.push_back(d);
    end
    bus_stop;
    idle(Q);
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < N; i++) chk(tag, regs[i*8 +: 8], model[i]);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0)
        chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    for (int i = 0; i < N; i++) model[i] = 8'h00;
    model[1] = 8'h48; model[6] = 8'h10;
    model[2] = 8'h16; model[3] = 8'h7C; model[4] = 8'hF0; model[5] = 8'h21;
    mfreq = 32'h21F07C16;

    idle(5); rst_ni = 1'b1; idle(5);
    // R7 and R10: reset defaults at their bit positions
    check_regs("R7 R10 reset value");
    chk("R8 reset freq word", freq, mfreq);
    chk("R1 idle released", sda_oe, 0);

    // R2: foreign address is not acknowledged and writes nothing
    bus_start;
    send_byte({7'h2A, 1'b0}, ack); chk("R2 foreign address nack", ack, 1);
    send_byte(8'h03, ack);         chk("R2 ignored after mismatch", ack, 1);
    send_byte(8'hEE, ack);
    bus_stop; idle(Q);
    check_regs("R2 no write on mismatch");

    // R4: single register write
    write_regs(8'd7, 1, 8'hA5, 0, 0, 0);
    check_regs("R4 single write");

    // R8: partial frequency write does not move the word
    write_regs(8'd2, 3, 8'h11, 8'h22, 8'h33, 0);
    chk("R8 partial write holds word", freq, 32'h21F07C16);
    check_regs("R4 burst write");
    write_regs(8'd5, 1, 8'h44, 0, 0, 0);
    chk("R8 commit on top byte", freq, 32'h44332211);
    write_regs(8'd2, 4, 8'hAA, 8'hBB, 8'hCC, 8'hDD);
    chk("R8 full ordered write", freq, 32'hDDCCBBAA);
    chk("R8 model agrees", freq, mfreq);

    // R5: burst read from 0
    read_regs(8'd0, 5, "R5 burst read");

    // R6: write and read across the end of the bank
    write_regs(8'd24, 3, 8'h5A, 8'h6B, 8'h7C, 0);
    check_regs("R6 write wrap");
    read_regs(8'd25, 2, "R6 read wrap");

    // R3: out-of-range subaddress selects register 0
    write_regs(8'd30, 1, 8'h99, 0, 0, 0);
    check_regs("R3 out of range subaddress");

    // R1: stop in mid-byte writes nothing and releases bus
    bus_start;
    send_byte({my_addr, 1'b0}, ack);
    send_byte(8'd8, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop; idle(Q);
    chk("R1 released after stop", sda_oe, 0);
    check_regs("R1 aborted byte not written");
    write_regs(8'd8, 1, 8'h3C, 0, 0, 0);
    check_regs("R1 transfer after stop");

    // R9: repeated start inside the address byte
    bus_start;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start;
    send_byte({my_addr, 1'b0}, ack); chk("R9 address after restart", ack, 0);
    send_byte(8'd9, ack);
    send_byte(8'h77, ack);
    bus_stop; idle(Q);
    model[9] = 8'h77;
    check_regs("R9 write after restart");

    // R2: strap moves the address
    sel = 1'b1; idle(Q);
    bus_start;
    send_byte({7'h28, 1'b0}, ack); chk("R2 old address nack with strap", ack, 1);
    bus_stop; idle(Q);
    my_addr = 7'h2A;
    write_regs(8'd10, 1, 8'h5E, 0, 0, 0);
    read_regs(8'd10, 1, "R2 R5 read at strapped address");
    check_regs("R2 strapped write");

    idle(50);
    chk("R5 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule